// File: doc/BRIEF.md
# Dual-Width Read-Only Memory Port

This block is the device side of a read port on a mask-programmed read-only array. The contents of the array are a fixed hash of the address, so no storage or initialisation file is needed. The array can be read as 16-bit words or as 8-bit bytes. A host selects the width with a mode input, presents an address, and controls the outputs with a chip enable and an output enable. Every output bit has its own enable flag, which stands in for a tristate pad. A low enable flag means the pad is at high impedance.

One pad is shared between the two widths. In word mode the port drives the top data bit onto it. In byte mode the host drives it, and it supplies the lowest bit of the byte address. The port samples its inputs on each rising clock edge, and the outputs and their enable flags appear on the next edge. A build-time option decides how the output-enable input is read: active low, active high, or ignored.

Top module: `rom_dual_port`

## Requirements
- R1: In word mode (`word_mode`=1), `data_q[14:0]` carries bits 14:0 of the word at `addr`, and `msb_q` carries bit 15. The value appears one clock after the inputs are sampled.
- R2: In byte mode (`word_mode`=0), the byte address is {`addr`,`lsb_in`}. When `lsb_in`=0, bits 7:0 of the word appear on `data_q[7:0]`. When `lsb_in`=1, bits 15:8 of the word appear there.
- R3: In byte mode, `data_drv[14:8]` and `msb_drv` are 0, so those pads are high impedance. This holds even when reads are otherwise enabled.
- R4: The word at address a is defined as follows. Let L = a mod 65536 and H = a / 65536. The word is (L*0x9E37 mod 65536) XOR {L[7:0],L[15:8]} XOR H XOR 0x5A3C.
- R5: With `OE_OPT`=0, outputs are driven only when `chip_en_n`=0 and `out_en`=0.
- R6: With `OE_OPT`=1, outputs are driven only when `chip_en_n`=0 and `out_en`=1.
- R7: With `OE_OPT`=2, outputs are driven whenever `chip_en_n`=0, and `out_en` has no effect.
- R8: With `OE_OPT`=3, the port behaves exactly as with option 0.
- R9: When `chip_en_n`=1, every enable flag (`data_drv`, `msb_drv`) is 0 on the next clock, whatever the level of `out_en`.
- R10: While `rst_n`=0 at a clock edge, every enable flag is cleared.
- R11: When enabled in word mode, all 15 bits of `data_drv` and `msb_drv` are 1. When enabled in byte mode, exactly `data_drv[7:0]` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_n | input | 1 | Chip enable, active low; high selects standby |
| out_en | input | 1 | Output enable; its polarity is set by `OE_OPT` |
| word_mode | input | 1 | 1 = 16-bit word reads, 0 = 8-bit byte reads |
| addr | input | ADDR_W | Word address, or the upper part of the byte address |
| lsb_in | input | 1 | Shared pad as input: lowest byte-address bit in byte mode |
| data_q | output | 15 | Data output bits 14:0 |
| data_drv | output | 15 | Per-bit drive enable for `data_q`; 0 means high impedance |
| msb_q | output | 1 | Shared pad as output: data bit 15 in word mode |
| msb_drv | output | 1 | Drive enable for `msb_q` |

## Verification
A width change and a reversal of direction on the shared pad can happen on the same clock edge. In that cycle the pad stops being an output and becomes the byte-select input, or the reverse. The bench switches `word_mode` and changes `lsb_in` on the same edge while reads stay enabled. On the next cycle it checks three things: that `msb_drv` and the upper enable flags follow the new mode, and that `data_q[7:0]` carries the byte picked by the new `lsb_in`, not the old value. It also switches back within a single cycle, and checks that the word read and `msb_q` return one clock later.

// File: rtl/rom_port_pkg.sv
// Package: shared constants and the content function of the read-only array.
// Assumes a 16-bit array word; the address is passed in zero-extended to 32 bits.
package rom_port_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = WORD_W / 2;
    localparam int LOW_W  = WORD_W - 1;

    // Output-enable interpretation codes for the OE_OPT parameter.
    localparam int OE_ACT_LOW  = 0;
    localparam int OE_ACT_HIGH = 1;
    localparam int OE_IGNORE   = 2;

    // Content of the array: a fixed mix of the address bits.
    function automatic logic [WORD_W-1:0] rom_content(input logic [31:0] a);
        logic [15:0] lo;
        logic [15:0] prod;
        lo   = a[15:0];
        prod = lo * 16'h9E37;
        return prod ^ {lo[7:0], lo[15:8]} ^ a[31:16] ^ 16'h5A3C;
    endfunction

endpackage

// File: rtl/rom_enable_dec.sv
// Module: decides whether the port drives its pads this cycle.
// Assumes the chip enable is active low; OE_OPT picks how out_en is read
// (0 active low, 1 active high, 2 ignored, any other value active low).
module rom_enable_dec #(
    parameter int OE_OPT = 0
) (
    input  logic chip_en_n,
    input  logic out_en,
    output logic drive_en
);
    import rom_port_pkg::*;

    generate
        if (OE_OPT == OE_ACT_HIGH) begin : g_high
            // Drive when selected and the enable is high.
            always_comb drive_en = !chip_en_n && out_en;
        end else if (OE_OPT == OE_IGNORE) begin : g_ignore
            // Drive whenever selected; the enable pin is unused.
            logic unused_oe;
            always_comb unused_oe = out_en;
            always_comb drive_en = !chip_en_n;
        end else begin : g_low
            // Drive when selected and the enable is low (also the fallback).
            always_comb drive_en = !chip_en_n && !out_en;
        end
    endgenerate

endmodule

// File: rtl/rom_word_array.sv
// Module: the read-only array, holding one 16-bit word per address.
// Assumes the contents come from rom_content(); no storage is built.
module rom_word_array #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]                 addr,
    output logic [rom_port_pkg::WORD_W-1:0]   word
);
    import rom_port_pkg::*;

    // Look up the word for the presented address.
    always_comb word = rom_content(32'(addr));

endmodule

// File: rtl/rom_lane_mux.sv
// Module: steers the word, or one of its bytes, onto the pad lanes and
// builds a drive flag for each lane.
// Assumes the byte with select bit 0 is the low half of the word.
module rom_lane_mux (
    input  logic [rom_port_pkg::WORD_W-1:0] word,
    input  logic                            word_mode,
    input  logic                            byte_sel,
    input  logic                            drive_en,
    output logic [rom_port_pkg::LOW_W-1:0]  lane_d,
    output logic [rom_port_pkg::LOW_W-1:0]  lane_oe,
    output logic                            top_d,
    output logic                            top_oe
);
    import rom_port_pkg::*;

    logic [BYTE_W-1:0] picked;

    // Choose the half of the word addressed by the byte select.
    always_comb picked = byte_sel ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];

    // Data lanes: the full word in word mode, the picked byte in byte mode.
    always_comb begin
        lane_d = '0;
        if (word_mode) lane_d = word[LOW_W-1:0];
        else           lane_d[BYTE_W-1:0] = picked;
    end

    // The shared pad carries the top bit and is driven only in word mode.
    always_comb top_d  = word[WORD_W-1];
    always_comb top_oe = drive_en && word_mode;

    genvar i;
    generate
        for (i = 0; i < LOW_W; i++) begin : g_lane
            if (i < BYTE_W) begin : g_lower
                // Lower lanes are driven in both modes.
                always_comb lane_oe[i] = drive_en;
            end else begin : g_upper
                // Upper lanes are driven only in word mode.
                always_comb lane_oe[i] = drive_en && word_mode;
            end
        end
    endgenerate

endmodule

// File: rtl/rom_dual_port.sv
// Module: top of the dual-width read port. Samples its inputs on each rising
// edge and presents data and drive flags one clock later.
// Assumes synchronous active-low reset; a drive flag of 0 means high impedance.
module rom_dual_port #(
    parameter int ADDR_W = 8,
    parameter int OE_OPT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              out_en,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lsb_in,
    output logic [14:0]       data_q,
    output logic [14:0]       data_drv,
    output logic              msb_q,
    output logic              msb_drv
);
    import rom_port_pkg::*;

    logic                drive_en;
    logic [WORD_W-1:0]   word;
    logic [LOW_W-1:0]    lane_d;
    logic [LOW_W-1:0]    lane_oe;
    logic                top_d;
    logic                top_oe;

    rom_enable_dec #(.OE_OPT(OE_OPT)) u_dec (
        .chip_en_n (chip_en_n),
        .out_en    (out_en),
        .drive_en  (drive_en)
    );

    rom_word_array #(.ADDR_W(ADDR_W)) u_array (
        .addr (addr),
        .word (word)
    );

    rom_lane_mux u_mux (
        .word      (word),
        .word_mode (word_mode),
        .byte_sel  (lsb_in),
        .drive_en  (drive_en),
        .lane_d    (lane_d),
        .lane_oe   (lane_oe),
        .top_d     (top_d),
        .top_oe    (top_oe)
    );

    // Output register: clears the drive flags in reset, else captures the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            data_drv <= '0;
            msb_q    <= 1'b0;
            msb_drv  <= 1'b0;
        end else begin
            data_q   <= lane_d;
            data_drv <= lane_oe;
            msb_q    <= top_d;
            msb_drv  <= top_oe;
        end
    end

    // R9: standby leaves every pad undriven.
    p_standby_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(chip_en_n) |-> (data_drv == '0) && !msb_drv);

    // R3: byte mode never drives the upper lanes or the shared pad.
    p_byte_upper_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(word_mode) |-> (data_drv[14:8] == '0) && !msb_drv);

    // R11: an enabled word read drives every lane and the shared pad.
    p_word_full_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(drive_en) && $past(word_mode)
        |-> (data_drv == '1) && msb_drv);

    // R2: an enabled high-byte read carries the upper half of the array word.
    p_high_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(drive_en) && !$past(word_mode) && $past(lsb_in)
        |-> data_q[7:0] == $past(word[15:8]));

    // R1: an enabled word read carries the top bit on the shared pad.
    p_word_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(drive_en) && $past(word_mode)
        |-> msb_q == $past(word[15]));

endmodule

// File: tb/rom_dual_port_tb.sv
// Directed bench: four instances share all inputs and differ only in OE_OPT.
module rom_dual_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chip_en_n = 1'b1;
    logic              out_en = 1'b0;
    logic              word_mode = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              lsb_in = 1'b0;

    logic [14:0] d0, e0, d1, e1, d2, e2, d3, e3;
    logic        m0, me0, m1, me1, m2, me2, m3, me3;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_dual_port #(.ADDR_W(ADDR_W), .OE_OPT(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en(out_en),
        .word_mode(word_mode), .addr(addr), .lsb_in(lsb_in),
        .data_q(d0), .data_drv(e0), .msb_q(m0), .msb_drv(me0));
    rom_dual_port #(.ADDR_W(ADDR_W), .OE_OPT(1)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en(out_en),
        .word_mode(word_mode), .addr(addr), .lsb_in(lsb_in),
        .data_q(d1), .data_drv(e1), .msb_q(m1), .msb_drv(me1));
    rom_dual_port #(.ADDR_W(ADDR_W), .OE_OPT(2)) u_dut_dc (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en(out_en),
        .word_mode(word_mode), .addr(addr), .lsb_in(lsb_in),
        .data_q(d2), .data_drv(e2), .msb_q(m2), .msb_drv(me2));
    rom_dual_port #(.ADDR_W(ADDR_W), .OE_OPT(3)) u_dut_fb (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en(out_en),
        .word_mode(word_mode), .addr(addr), .lsb_in(lsb_in),
        .data_q(d3), .data_drv(e3), .msb_q(m3), .msb_drv(me3));

    // Expected array word, built from the formula in R4.
    function automatic logic [15:0] exp_word(input int a);
        logic [15:0] l;
        logic [15:0] p;
        l = a[15:0];
        p = l * 16'h9E37;
        return p ^ {l[7:0], l[15:8]} ^ a[31:16] ^ 16'h5A3C;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one set of inputs, then move to the sampling point after the next edge.
    task automatic apply(input logic ce_n, input logic oe, input logic wm,
                         input int a, input logic lsb);
        @(negedge clk);
        chip_en_n = ce_n; out_en = oe; word_mode = wm;
        addr = a[ADDR_W-1:0]; lsb_in = lsb;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chip_en_n = 1'b0; out_en = 1'b0; word_mode = 1'b1; out_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 flags cleared opt0", {e0, me0}, 32'h0);
        chk("R10 flags cleared opt2", {e2, me2}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_word_reads();
        for (int a = 0; a < 256; a += 37) begin
            logic [15:0] w;
            w = exp_word(a);
            apply(1'b0, 1'b0, 1'b1, a, 1'b0);
            chk("R1 word low bits", d0, w[14:0]);
            chk("R1 word top bit", m0, w[15]);
            chk("R11 word drive", {e0, me0}, 32'hFFFF);
        end
        // R4: highest address of the array.
        apply(1'b0, 1'b0, 1'b1, 255, 1'b0);
        chk("R4 content at top address", {m0, d0}, exp_word(255));
    endtask

    task automatic t_byte_reads();
        for (int a = 3; a < 256; a += 50) begin
            logic [15:0] w;
            w = exp_word(a);
            apply(1'b0, 1'b0, 1'b0, a, 1'b0);
            chk("R2 low byte", d0[7:0], w[7:0]);
            chk("R11 byte drive", e0, 32'h00FF);
            chk("R3 shared pad released", me0, 1'b0);
            apply(1'b0, 1'b0, 1'b0, a, 1'b1);
            chk("R2 high byte", d0[7:0], w[15:8]);
            chk("R3 upper lanes undriven", e0[14:8], 7'h0);
        end
    endtask

    task automatic t_options();
        // Enabled low: option 0 and 3 drive, option 1 idle, option 2 drives.
        apply(1'b0, 1'b0, 1'b1, 9, 1'b0);
        chk("R5 opt0 drives with oe low", e0, 32'h7FFF);
        chk("R6 opt1 idle with oe low", {e1, me1}, 32'h0);
        chk("R7 opt2 drives with oe low", e2, 32'h7FFF);
        chk("R8 opt3 drives with oe low", e3, 32'h7FFF);
        apply(1'b0, 1'b1, 1'b1, 9, 1'b0);
        chk("R5 opt0 idle with oe high", {e0, me0}, 32'h0);
        chk("R6 opt1 drives with oe high", {e1, me1}, 32'hFFFF);
        chk("R6 opt1 data", {m1, d1}, exp_word(9));
        chk("R7 opt2 drives with oe high", {e2, me2}, 32'hFFFF);
        chk("R8 opt3 idle with oe high", {e3, me3}, 32'h0);
    endtask

    task automatic t_standby();
        for (int oe = 0; oe < 2; oe++) begin
            apply(1'b1, oe[0], 1'b1, 20, 1'b0);
            chk("R9 standby opt0", {e0, me0}, 32'h0);
            chk("R9 standby opt1", {e1, me1}, 32'h0);
            chk("R9 standby opt2", {e2, me2}, 32'h0);
            chk("R9 standby opt3", {e3, me3}, 32'h0);
        end
    endtask

    task automatic t_mode_switch();
        logic [15:0] w;
        w = exp_word(77);
        apply(1'b0, 1'b0, 1'b1, 77, 1'b0);
        chk("R1 before switch", {m0, d0}, w);
        // Width change and pad reversal on the same edge.
        apply(1'b0, 1'b0, 1'b0, 77, 1'b1);
        chk("R2 byte after switch", d0[7:0], w[15:8]);
        chk("R3 pad released after switch", {e0[14:8], me0}, 8'h0);
        apply(1'b0, 1'b0, 1'b1, 77, 1'b0);
        chk("R1 word restored", {m0, d0}, w);
        chk("R11 full drive restored", {e0, me0}, 32'hFFFF);
    endtask

    initial begin
        t_reset();
        t_word_reads();
        t_byte_reads();
        t_options();
        t_standby();
        t_mode_switch();
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule